// File: doc/BRIEF.md
# Slew-Limited Current-Level Ramp Controller

This block drives the code register of a 10-bit current DAC for a voice-coil motor. Each code step stands for 100 µA, so code 1023 is full scale. When a new level is loaded together with a 4-bit ramp code, the register does not jump to the new value. It walks toward it one LSB per update and waits a programmable number of clock cycles between updates. The DAC itself, the current sink and the serial-bus decoding sit outside this block.

Ramp codes fall into three groups:
- **Step response.** These codes insert no wait, so the code moves by one every cycle.
- **Single interval.** These codes use one wait for the whole move.
- **Dual interval.** These codes use a short wait until the move passes its midpoint. After that they use a longer wait, which gives a fast approach and a soft landing.

All waits are parameters counted in clock cycles. A fault or power-up reset clears the code to zero. The active-low sleep input freezes all activity and turns the output off.

Top module: `vcm_ramp_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous), and on the clock edge after `fault_i` is sampled high (synchronous), the code and the stored target become 0. After that, `busy_o` and `out_en_o` read 0.
- R2: Between two clock edges the code changes by at most one LSB. It keeps stepping toward the stored target until it equals it.
- R3: Ramp codes 4'b0000, 4'b0001, 4'b1000 and 4'b1001 give a step response. The first step happens on the edge after the load edge, and one step follows on every later edge.
- R4: Ramp codes 4'b0010 to 4'b0111 (bit 3 = 0) give a single interval of W = `SINGLE_BASE` << (bits[2:0] − 2) cycles. The first step comes W+1 edges after the load edge, and every later step comes W+1 edges after the previous one.
- R5: Ramp codes 4'b1010 to 4'b1111 (bit 3 = 1) give a dual interval.
  - The switchover code is S = min(start, target) + |target − start| / 2.
  - A step that leaves a code still on the start side of S (strictly) takes `DUAL_FIRST`+1 cycles.
  - Every other step takes (`DUAL_BASE` << (bits[2:0] − 2))+1 cycles.
  - Ramp code 4'b1100 gives a second wait of 4·`DUAL_BASE`. Ramp code 4'b1101 gives 8·`DUAL_BASE`.
- R6: While `sleep_n_i` is low, the code and the wait count hold, loads are ignored and `out_en_o` is 0. After wake-up the interrupted ramp resumes toward the old target.
- R7: `out_en_o` is 1 only when the block is awake and the code is not 0.
- R8: A load during a ramp keeps the current code on the load edge. It then steps toward the new target, and the direction and switchover point are recomputed from that code.
- R9: `busy_o` is 1 exactly when the code differs from the stored target. With no load, a settled code stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| fault_i | input | 1 | Supply fault, synchronous clear to code 0 |
| sleep_n_i | input | 1 | Active-low sleep |
| load_i | input | 1 | One-cycle strobe that accepts a new target and ramp code |
| target_i | input | CODE_W | New level code |
| ramp_i | input | 4 | Ramp code |
| code_o | output | CODE_W | Present DAC code |
| out_en_o | output | 1 | Output sink enable |
| busy_o | output | 1 | Code differs from target |

## Verification
On every cycle, the assertions check these properties:
- The code moves by at most one LSB per cycle.
- A fault leaves the code at zero and the block idle.
- Sleep freezes the code and disables the output.
- A settled code stays where it is.

Only the directed scenarios can show the following:
- The cycle spacing that each ramp-code group produces.
- The placement of the dual-interval switchover in both directions.
- A sleep-interrupted ramp resuming toward its old target.
- A mid-ramp retarget reversing direction from the current code.

// File: rtl/vcm_ramp_ctrl.sv
module vcm_ramp_ctrl #(
  parameter int CODE_W      = 10,
  parameter int DLY_W       = 16,
  parameter int SINGLE_BASE = 2,
  parameter int DUAL_FIRST  = 1,
  parameter int DUAL_BASE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic              sleep_n_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] target_i,
  input  logic [3:0]        ramp_i,
  output logic [CODE_W-1:0] code_o,
  output logic              out_en_o,
  output logic              busy_o
);
  logic [CODE_W-1:0] code_q, tgt_q, sw_q;
  logic [3:0]        ramp_q;
  logic [DLY_W-1:0]  cnt_q;

  function automatic logic [DLY_W-1:0] wait_for(input logic [3:0] r,
      input logic [CODE_W-1:0] c, input logic [CODE_W-1:0] t,
      input logic [CODE_W-1:0] s);
    logic [2:0] sh;
    logic early;
    sh    = r[2:0] - 3'd2;
    early = (c < t) ? (c < s) : (c > s);
    if (r[2:0] < 3'd2)       return '0;
    else if (!r[3])          return DLY_W'(SINGLE_BASE) << sh;
    else if (early)          return DLY_W'(DUAL_FIRST);
    else                     return DLY_W'(DUAL_BASE) << sh;
  endfunction

  logic [CODE_W-1:0] lo, span, sw_new, code_nxt;
  assign lo       = (code_q < target_i) ? code_q : target_i;
  assign span     = (code_q < target_i) ? target_i - code_q : code_q - target_i;
  assign sw_new   = lo + (span >> 1);
  assign code_nxt = (code_q < tgt_q) ? code_q + 1'b1 : code_q - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0; tgt_q <= '0; sw_q <= '0; ramp_q <= '0; cnt_q <= '0;
    end else if (fault_i) begin
      code_q <= '0; tgt_q <= '0; sw_q <= '0; ramp_q <= '0; cnt_q <= '0;
    end else if (sleep_n_i) begin
      if (load_i) begin
        tgt_q  <= target_i;
        ramp_q <= ramp_i;
        sw_q   <= sw_new;
        cnt_q  <= wait_for(ramp_i, code_q, target_i, sw_new);
      end else if (code_q != tgt_q) begin
        if (cnt_q == '0) begin
          code_q <= code_nxt;
          cnt_q  <= wait_for(ramp_q, code_nxt, tgt_q, sw_q);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign code_o   = code_q;
  assign busy_o   = code_q != tgt_q;
  assign out_en_o = sleep_n_i && (code_q != '0);
endmodule

module vcm_ramp_ctrl_chk #(parameter int CODE_W = 10) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_i,
  input logic              sleep_n_i,
  input logic              load_i,
  input logic [CODE_W-1:0] code_o,
  input logic              out_en_o,
  input logic              busy_o
);
  a_r2_one_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_i |=> (code_o == $past(code_o) || code_o == $past(code_o) + 1'b1
                  || code_o == $past(code_o) - 1'b1));
  a_r1_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (code_o == '0 && !busy_o));
  a_r6_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n_i && !fault_i) |=> $stable(code_o));
  a_r6_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |-> !out_en_o);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i && !fault_i) |=> ($stable(code_o) && !busy_o));
endmodule

bind vcm_ramp_ctrl vcm_ramp_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .sleep_n_i(sleep_n_i),
  .load_i(load_i), .code_o(code_o), .out_en_o(out_en_o), .busy_o(busy_o));

// File: tb/vcm_ramp_ctrl_bench.sv
module vcm_ramp_ctrl_bench;
  logic       clk = 0, rst_n = 0, fault_i = 0, sleep_n_i = 1, load_i = 0;
  logic [9:0] target_i = '0, code_o;
  logic [3:0] ramp_i = '0;
  logic       out_en_o, busy_o;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  vcm_ramp_ctrl u_vcm_ramp_ctrl (.clk(clk), .rst_n(rst_n), .fault_i(fault_i),
    .sleep_n_i(sleep_n_i), .load_i(load_i), .target_i(target_i), .ramp_i(ramp_i),
    .code_o(code_o), .out_en_o(out_en_o), .busy_o(busy_o));

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input int t, input logic [3:0] r);
    @(negedge clk); load_i = 1; target_i = 10'(t); ramp_i = r;
    @(posedge clk); #1 load_i = 0;
  endtask

  task automatic clear();
    @(negedge clk); fault_i = 1;
    @(posedge clk); #1 fault_i = 0;
  endtask

  task automatic t_reset();
    check("R1 code", code_o, 0); check("R1 busy", busy_o, 0);
    check("R7 oe", out_en_o, 0);
  endtask

  task automatic t_step();
    clear(); load(5, 4'b0000);
    edges(1); check("R3 first step", code_o, 1); check("R7 oe", out_en_o, 1);
    check("R9 busy", busy_o, 1);
    edges(4); check("R3 end", code_o, 5); check("R9 idle", busy_o, 0);
    edges(3); check("R9 hold", code_o, 5);
    load(2, 4'b1001); edges(1); check("R3 down", code_o, 4);
    edges(1); check("R2 down", code_o, 3);
  endtask

  task automatic t_single();
    clear(); load(2, 4'b0010);
    edges(2); check("R4 wait", code_o, 0);
    edges(1); check("R4 step1", code_o, 1);
    edges(2); check("R4 wait2", code_o, 1);
    edges(1); check("R4 step2", code_o, 2);
    clear(); load(1, 4'b0100);
    edges(8); check("R4 long wait", code_o, 0);
    edges(1); check("R4 long step", code_o, 1);
  endtask

  task automatic t_dual();
    clear(); load(4, 4'b1100);
    edges(4); check("R5 up fast", code_o, 2);
    edges(12); check("R5 up slow wait", code_o, 2);
    edges(1); check("R5 up slow step", code_o, 3);
    edges(13); check("R5 up end", code_o, 4); check("R9 end", busy_o, 0);
    load(0, 4'b1100);
    edges(4); check("R5 down fast", code_o, 2);
    edges(12); check("R5 down wait", code_o, 2);
    edges(1); check("R5 down step", code_o, 1);
    edges(13); check("R5 down end", code_o, 0);
    clear(); load(2, 4'b1101);
    edges(2); check("R5 1101 fast", code_o, 1);
    edges(24); check("R5 1101 wait", code_o, 1);
    edges(1); check("R5 1101 step", code_o, 2);
  endtask

  task automatic t_sleep_fault();
    clear(); load(10, 4'b0010);
    edges(3); check("R4 pre-sleep", code_o, 1);
    sleep_n_i = 0;
    edges(10); check("R6 frozen", code_o, 1); check("R6 oe", out_en_o, 0);
    load(0, 4'b0000); edges(2); check("R6 load ignored", code_o, 1);
    check("R6 target kept", busy_o, 1);
    @(negedge clk); sleep_n_i = 1;
    edges(2); check("R6 resume wait", code_o, 1);
    edges(1); check("R6 resume", code_o, 2); check("R7 awake", out_en_o, 1);
    clear(); check("R1 fault code", code_o, 0); check("R1 fault busy", busy_o, 0);
    check("R1 fault oe", out_en_o, 0);
  endtask

  task automatic t_retarget();
    clear(); load(6, 4'b0000);
    edges(3); check("R8 mid", code_o, 3);
    load(1, 4'b0000); check("R8 load edge", code_o, 3);
    edges(1); check("R8 reverse", code_o, 2);
    edges(1); check("R8 end", code_o, 1); check("R9 settled", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    edges(1);
    t_reset(); t_step(); t_single(); t_dual(); t_sleep_fault(); t_retarget();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule